// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches one external interrupt pin and turns it into an interrupt request according to a two-bit sense mode. Three of the modes are edge modes: any edge, falling edge and rising edge. An edge is recognised only while the I/O clock enable is high. It sets a sticky flag, and that flag holds until an acknowledge pulse clears it. The fourth mode is low level. In that mode there is no sticky state, and the request simply reflects the synchronised pin. The pin input is sampled regardless of how the pad is driven, so software that drives the pin itself can raise the interrupt.

Next to the clocked path there is a purely combinational wake path. With the block enabled in low-level mode, a low pin asserts the wake request at once, with no clock edge needed. The sleep logic can therefore start a wake-up even when the I/O clock is halted. The I/O clock is halted in every sleep state except idle. If the pin returns high before it has been synchronised, the wake request has already done its job, but no interrupt request is issued.

Top module: `ext_irq_sense`

## Requirements
- R1: The mode field `sense_i` is decoded as 00 = low level, 01 = any edge, 10 = falling edge (1 to 0), 11 = rising edge (0 to 1). In an edge mode, only the selected transition raises `irq_o`.
- R2: In low-level mode with `enable_i` high, `irq_o` is high exactly while the pin, seen through a two-flop synchronizer, is low. It follows a pin change two rising clock edges later and never stays high once the pin is high again.
- R3: An edge is recognised only when `io_clk_en_i` is high. A qualifying pin transition sets `irq_o` on the third rising edge after the change. A transition that occurs while `io_clk_en_i` is low is never recognised.
- R4: `wake_o` is high, combinationally and without any clock edge, exactly when `enable_i` is high, `sense_i` is 00 and `pin_i` is low. It is low in every edge mode.
- R5: In edge modes the request is sticky. It stays high until `ack_i` is sampled high, and it is low on the following cycle. If a new edge is recognised in the same cycle as the acknowledge, the request stays high.
- R6: A change of `sense_i` clears any pending edge flag on the first rising edge that sees the new value, so a mode switch raises no request.
- R7: With `enable_i` low, `irq_o` and `wake_o` are low, and edges that occur meanwhile leave no pending flag.
- R8: During and right after reset, `irq_o` is low and no flag is pending.
- R9: A low pulse on the pin that falls between two clock samples asserts `wake_o` while it lasts but never asserts `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external interrupt pin level |
| io_clk_en_i | input | 1 | High while the I/O clock runs; gates edge recognition |
| sense_i | input | 2 | Sense mode: 00 low, 01 any edge, 10 falling, 11 rising |
| enable_i | input | 1 | Interrupt enable |
| ack_i | input | 1 | Acknowledge pulse; clears the pending edge flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Asynchronous wake request (low-level mode only) |

## Verification
Each result has its own latency, counted from a pin change made at a falling clock edge. The wake request is due in the same instant, with no clock edge. The level-mode request is due after two rising edges. The edge-mode request is due after three. The clearing effect of an acknowledge or a mode change shows after one. The bench drives every input at a falling edge and waits a counted number of falling edges before it samples. For the latency cases it also samples one cycle early, to confirm that the output has not yet moved. The async cases are checked a fraction of a nanosecond after the pin moves, between clock edges, so no sample of the synchronizer can have taken place.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int unsigned SENSE_W = 2;

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eis_edge_det.sv
module eis_edge_det
  import ext_irq_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               samp_i,
  input  logic               clk_en_i,
  input  logic [SENSE_W-1:0] sense_i,
  output logic               hit_o
);

  logic prev_q;
  logic rise;
  logic fall;

  // previous sample tracks continuously so a halt cannot leave a stale edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= samp_i;
  end

  assign rise = samp_i & ~prev_q;
  assign fall = ~samp_i & prev_q;

  always_comb begin
    hit_o = 1'b0;
    if (clk_en_i) begin
      unique case (sense_e'(sense_i))
        SENSE_ANY:  hit_o = rise | fall;
        SENSE_FALL: hit_o = fall;
        SENSE_RISE: hit_o = rise;
        default:    hit_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/eis_flag.sv
module eis_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (clr_i)  flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (ack_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !flag_q); // R5
  AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> flag_q); // R5
  AST_MODE_SWITCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_q); // R6

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        PIN_IDLE    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_i,
  input  logic               io_clk_en_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic               enable_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic               wake_o
);

  logic               pin_s;
  logic               hit;
  logic               flag_q;
  logic [SENSE_W-1:0] sense_q;
  logic               sense_chg;
  logic               level_mode;
  logic               edge_set;

  eis_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  eis_edge_det #(
    .RST_VAL (PIN_IDLE)
  ) edge_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp_i   (pin_s),
    .clk_en_i (io_clk_en_i),
    .sense_i  (sense_i),
    .hit_o    (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= SENSE_LOW;
    else        sense_q <= sense_i;
  end

  assign sense_chg  = (sense_i != sense_q);
  assign level_mode = (sense_e'(sense_i) == SENSE_LOW);
  assign edge_set   = hit & enable_i & ~level_mode;

  eis_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (edge_set),
    .ack_i  (ack_i),
    .clr_i  (sense_chg),
    .flag_o (flag_q)
  );

  // level request follows the synchronised pin; edge request is the sticky flag
  assign irq_o  = enable_i & (level_mode ? ~pin_s : flag_q);
  // clock-free wake path straight from the pad
  assign wake_o = enable_i & level_mode & ~pin_i;

  AST_NO_EDGE_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_clk_en_i && !flag_q) |=> !flag_q); // R3
  AST_LEVEL_NOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_e'(sense_q) == SENSE_LOW && $past(sense_q) == SENSE_LOW) |-> !flag_q); // R2

endmodule

// File: tb/ext_irq_sense_tb_top.sv
`timescale 1ns/100ps
module ext_irq_sense_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1;
  logic       clk_en = 1'b1;
  logic [1:0] sense = 2'b00;
  logic       en = 1'b0;
  logic       ack = 1'b0;
  logic       irq;
  logic       wake;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ext_irq_sense dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .io_clk_en_i (clk_en),
    .sense_i     (sense),
    .enable_i    (en),
    .ack_i       (ack),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  // {sense[1:0], enable, clk_en, pin_from, pin_to, exp_irq, exp_wake}
  localparam logic [7:0] VECS [0:12] = '{
    8'b00_1_1_1_0_1_1,  // R2 R4 level low
    8'b00_1_1_0_1_0_0,  // R2 level released
    8'b00_0_1_1_0_0_0,  // R7 disabled level
    8'b00_1_0_1_0_1_1,  // R4 level while clock halted
    8'b01_1_1_0_1_1_0,  // R1 any edge rising
    8'b01_1_1_1_0_1_0,  // R1 any edge falling
    8'b10_1_1_1_0_1_0,  // R1 falling match
    8'b10_1_1_0_1_0_0,  // R1 falling mode, rising pin
    8'b11_1_1_0_1_1_0,  // R1 rising match
    8'b11_1_1_1_0_0_0,  // R1 rising mode, falling pin
    8'b11_1_0_0_1_0_0,  // R3 edge while halted
    8'b10_0_1_1_0_0_0,  // R7 disabled edge
    8'b01_1_1_0_0_0_0   // R1 no transition
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R8 reset state
    step(2);
    chk("R8 irq in reset", irq, 1'b0);
    chk("R8 wake disabled", wake, 1'b0);
    rst_n = 1'b1;
    step(3);
    chk("R8 irq after reset", irq, 1'b0);

    // table walk
    for (int v = 0; v < 13; v++) begin
      sense  = VECS[v][7:6];
      en     = VECS[v][5];
      clk_en = VECS[v][4];
      pin    = VECS[v][3];
      step(4);
      ack = 1'b1;
      step(1);
      ack = 1'b0;
      pin = VECS[v][2];
      step(4);
      chk($sformatf("R1 vector %0d irq", v), irq, VECS[v][1]);
      chk($sformatf("R4 vector %0d wake", v), wake, VECS[v][0]);
    end

    // R3 edge latency and R5 stickiness
    sense = 2'b10; en = 1'b1; clk_en = 1'b1; pin = 1'b1;
    step(4); ack = 1'b1; step(1); ack = 1'b0;
    pin = 1'b0;
    step(2);
    chk("R3 no flag after two edges", irq, 1'b0);
    step(1);
    chk("R3 flag after three edges", irq, 1'b1);
    pin = 1'b1;
    step(8);
    chk("R5 flag held after pin release", irq, 1'b1);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R5 ack clears next cycle", irq, 1'b0);

    // R5 new edge coincident with ack
    sense = 2'b01;
    step(4); ack = 1'b1; step(1); ack = 1'b0;
    pin = 1'b0;
    step(4);
    chk("R5 any edge sets flag", irq, 1'b1);
    pin = 1'b1;
    step(2);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R5 edge beats ack", irq, 1'b1);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R5 second ack clears", irq, 1'b0);

    // R6 mode switch clears pending flag
    pin = 1'b0;
    step(4);
    chk("R6 flag pending before switch", irq, 1'b1);
    sense = 2'b11;
    step(1);
    chk("R6 switch clears flag", irq, 1'b0);
    step(3);
    chk("R6 stays clear", irq, 1'b0);

    // R2 level latency
    sense = 2'b00; pin = 1'b1;
    step(4);
    pin = 1'b0;
    step(1);
    chk("R2 level not yet after one edge", irq, 1'b0);
    step(1);
    chk("R2 level after two edges", irq, 1'b1);
    pin = 1'b1;
    step(2);
    chk("R2 level follows release", irq, 1'b0);

    // R7 edges while disabled leave nothing pending
    sense = 2'b01; en = 1'b0;
    step(4); ack = 1'b1; step(1); ack = 1'b0;
    pin = 1'b0;
    step(4);
    en = 1'b1;
    #0.1;
    chk("R7 no pending flag after enable", irq, 1'b0);

    // R4 R9 async wake with clock halted, glitch between samples
    sense = 2'b00; clk_en = 1'b0; pin = 1'b1;
    step(4);
    #0.5 pin = 1'b0;
    #0.2;
    chk("R4 wake without clock edge", wake, 1'b1);
    #0.3 pin = 1'b1;
    #0.1;
    chk("R9 wake drops with pin", wake, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(1);
      chk("R9 no irq from short pulse", irq, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule